// File: doc/BRIEF.md
# Bit-serial partial-sum cluster accumulator

This block sits behind eight processing elements that each produce four 9-bit partial sums per cycle, one per output kernel. The activation operand arrives one bit plane at a time, least significant bit first. The block rebuilds full-precision dot products from these slices. For every lane it adds the eight element contributions and shifts the total left by the index of the current activation bit. It then adds the shifted value into a per-lane accumulator.

A job begins with a one-cycle `start_i` pulse. The pulse clears the four accumulators and latches the activation precision. Each following cycle in which `step_i` is high supplies one bit plane. After as many planes as the precision, `valid_o` pulses for one cycle. The four final words then stay on `result_o` until the next start. Each final word covers 64 multiply-accumulates at full activation precision.

Top module: `psum_cluster_acc`

## Requirements
- R1: Out of reset, `valid_o` and `busy_o` are 0 and all four result words are 0.
- R2: A cycle with `start_i` high clears all four result words, raises `busy_o` and latches `prec_i`, all at the next clock edge.
- R3: Each accepted step adds, to lane l, the sum over elements e of the 9-bit field `psum_i[(e*4+l)*9 +: 9]`, shifted left by the current bit index. Lane l of the result is `result_o[l*20 +: 20]`.
- R4: Bit indices run 0, 1, 2 … in order of accepted steps. A cycle with `step_i` low while busy adds nothing and does not advance the index.
- R5: On the clock edge that accepts the step with index precision−1, the final words appear, `valid_o` rises for exactly one cycle and `busy_o` falls. `valid_o` stays low on every earlier step.
- R6: A precision of 0, or one above 8, runs 8 steps.
- R7: While idle, `step_i` and `psum_i` leave `result_o` unchanged.
- R8: When `start_i` and `step_i` are high in the same cycle, the start wins. The step is discarded, the accumulators clear and a new job begins. This also applies to the final step of a running job, which then gives no `valid_o`.
- R9: With every field at 511 and precision 8, each lane holds 1,042,440 with no wrap.
- R10: After completion, the result words hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears accumulators and begins a job |
| prec_i | input | 4 | Activation precision in bits, sampled with start |
| step_i | input | 1 | A bit plane is present on psum_i |
| psum_i | input | 288 | 32 partial sums of 9 bits, element-major |
| busy_o | output | 1 | Job in progress |
| valid_o | output | 1 | One-cycle pulse when results are final |
| result_o | output | 80 | Four 20-bit accumulated words |

## Verification
Two functions can fall in the same cycle: the restart that `start_i` requests and the accumulation of a bit plane. The bench raises both together in the middle of a running job, and again on the job's last plane. It then requires, one cycle later, zeroed results, `busy_o` high and no `valid_o` pulse. A fresh job started afterwards must still complete with the exact expected sums. This shows that the discarded plane left no trace in the accumulators or in the bit index.

// File: rtl/psum_cluster_pkg.sv
package psum_cluster_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_state_e;
endpackage

// File: rtl/psum_add_tree.sv
module psum_add_tree #(
  parameter int N_OP  = 8,
  parameter int IN_W  = 9,
  parameter int OUT_W = 12
) (
  input  logic [N_OP*IN_W-1:0] ops_i,
  output logic [OUT_W-1:0]     sum_o
);
  localparam int LEAVES = (N_OP > 1) ? (1 << $clog2(N_OP)) : 1;

  logic [OUT_W-1:0] node [1:2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N_OP) begin : g_op
      assign node[LEAVES+i] = OUT_W'(ops_i[i*IN_W +: IN_W]);
    end else begin : g_pad
      assign node[LEAVES+i] = '0;
    end
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    assign node[i] = node[2*i] + node[2*i+1];
  end

  assign sum_o = node[1];
endmodule

// File: rtl/psum_lane_acc.sv
module psum_lane_acc #(
  parameter int SUM_W = 12,
  parameter int ACC_W = 20,
  parameter int SH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] term;

  assign term = ACC_W'(sum_i) << shamt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= acc_q + term;
  end

  assign acc_o = acc_q;

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (acc_q >= $past(acc_q)));

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/psum_seq_ctrl.sv
module psum_seq_ctrl
  import psum_cluster_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int CNT_W    = 4,
  parameter int SH_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] prec_i,
  output logic             busy_o,
  output logic             clr_o,
  output logic             acc_en_o,
  output logic [SH_W-1:0]  shamt_o,
  output logic             done_o
);
  run_state_e       state_q;
  logic [CNT_W-1:0] prec_q;
  logic [CNT_W-1:0] prec_eff;
  logic [SH_W-1:0]  idx_q;
  logic             done_q;
  logic             fire;
  logic             last;

  assign prec_eff = (prec_i == '0 || prec_i > CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : prec_i;
  assign fire     = (state_q == ST_RUN) && step_i && !start_i;
  assign last     = (CNT_W'(idx_q) == prec_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      prec_q  <= CNT_W'(1);
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RUN;
        prec_q  <= prec_eff;
        idx_q   <= '0;
      end else if (fire) begin
        if (last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + SH_W'(1);
        end
      end
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign clr_o    = start_i;
  assign acc_en_o = fire;
  assign shamt_o  = idx_q;
  assign done_o   = done_q;

  assert_idx_below_prec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (CNT_W'(idx_q) < prec_q));

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));

  assert_prec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (prec_q != '0 && prec_q <= CNT_W'(MAX_BITS)));

  assert_start_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RUN && idx_q == '0 && !done_q));
endmodule

// File: rtl/psum_cluster_acc.sv
module psum_cluster_acc #(
  parameter int N_PE     = 8,
  parameter int N_LANE   = 4,
  parameter int PSUM_W   = 9,
  parameter int MAX_BITS = 8,
  localparam int CNT_W   = $clog2(MAX_BITS + 1),
  localparam int SH_W    = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int SUM_W   = PSUM_W + $clog2(N_PE),
  localparam int ACC_W   = SUM_W + MAX_BITS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [CNT_W-1:0]            prec_i,
  input  logic                        step_i,
  input  logic [N_PE*N_LANE*PSUM_W-1:0] psum_i,
  output logic                        busy_o,
  output logic                        valid_o,
  output logic [N_LANE*ACC_W-1:0]     result_o
);
  logic            clr;
  logic            acc_en;
  logic [SH_W-1:0] shamt;

  psum_seq_ctrl #(
    .MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .SH_W(SH_W)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .step_i   (step_i),
    .prec_i   (prec_i),
    .busy_o   (busy_o),
    .clr_o    (clr),
    .acc_en_o (acc_en),
    .shamt_o  (shamt),
    .done_o   (valid_o)
  );

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    logic [N_PE*PSUM_W-1:0] ops;
    logic [SUM_W-1:0]       lane_sum;

    for (genvar e = 0; e < N_PE; e++) begin : g_pick
      assign ops[e*PSUM_W +: PSUM_W] = psum_i[(e*N_LANE+l)*PSUM_W +: PSUM_W];
    end

    psum_add_tree #(
      .N_OP(N_PE), .IN_W(PSUM_W), .OUT_W(SUM_W)
    ) u_tree (
      .ops_i (ops),
      .sum_o (lane_sum)
    );

    psum_lane_acc #(
      .SUM_W(SUM_W), .ACC_W(ACC_W), .SH_W(SH_W)
    ) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .en_i    (acc_en),
      .shamt_i (shamt),
      .sum_i   (lane_sum),
      .acc_o   (result_o[l*ACC_W +: ACC_W])
    );
  end

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(result_o));

  assert_valid_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_o);

  assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == '0 && busy_o && !valid_o));

  assert_hold_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/psum_cluster_acc_test.sv
module psum_cluster_acc_test;
  localparam int NPE = 8, NL = 4, PW = 9, AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] prec = 4'd0;
  logic step = 1'b0;
  logic [NPE*NL*PW-1:0] psum;
  logic busy, valid;
  logic [NL*AW-1:0] result;

  logic [PW-1:0] ps [NPE][NL];
  longint exp_acc [NL];
  int checks = 0, failures = 0, cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always_comb
    for (int e = 0; e < NPE; e++)
      for (int l = 0; l < NL; l++)
        psum[(e*NL+l)*PW +: PW] = ps[e][l];

  psum_cluster_acc uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prec_i(prec),
    .step_i(step), .psum_i(psum), .busy_o(busy), .valid_o(valid), .result_o(result)
  );

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      summary();
    end
  end

  task automatic chk(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint lane_res(int l);
    return longint'(result[l*AW +: AW]);
  endfunction

  function automatic longint lane_sum(int l);
    longint s = 0;
    for (int e = 0; e < NPE; e++) s += longint'(ps[e][l]);
    return s;
  endfunction

  task automatic set_psum(input bit allmax);
    for (int e = 0; e < NPE; e++)
      for (int l = 0; l < NL; l++)
        ps[e][l] = allmax ? 9'h1FF : 9'($urandom_range(0, 511));
  endtask

  task automatic check_all(input string req);
    for (int l = 0; l < NL; l++) chk(req, lane_res(l), exp_acc[l] & 64'hFFFFF);
  endtask

  // drive start at a negedge, check at the next one
  task automatic begin_job(input int p);
    start = 1'b1; prec = 4'(p); step = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int l = 0; l < NL; l++) exp_acc[l] = 0;
    chk("R2 busy", longint'(busy), 1);
    check_all("R2 clear");
  endtask

  task automatic step_once(input int k, input bit allmax);
    set_psum(allmax);
    step = 1'b1;
    for (int l = 0; l < NL; l++) exp_acc[l] += lane_sum(l) << k;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic run_job(input int p, input int steps, input bit bubbles, input bit allmax);
    begin_job(p);
    for (int k = 0; k < steps; k++) begin
      if (bubbles && $urandom_range(0, 3) == 0) begin
        set_psum(1'b0); step = 1'b0;
        @(negedge clk);
        chk("R4 bubble valid", longint'(valid), 0);
      end
      step_once(k, allmax);
      if (k < steps - 1) chk("R5 early valid", longint'(valid), 0);
    end
    chk("R5 valid", longint'(valid), 1);
    chk("R5 busy", longint'(busy), 0);
    check_all("R3 R4 result");
    @(negedge clk);
    chk("R5 pulse", longint'(valid), 0);
    check_all("R10 hold");
    set_psum(1'b0); step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk("R7 idle valid", longint'(valid), 0);
    check_all("R7 idle ignore");
  endtask

  initial begin
    void'($urandom(32'd4242));
    set_psum(1'b0);
    #5;
    chk("R1 valid", longint'(valid), 0);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 result", longint'(result), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid post", longint'(valid), 0);

    // directed
    run_job(1, 1, 1'b0, 1'b0);
    run_job(8, 8, 1'b0, 1'b1);           // R9 worst case
    chk("R9 max lane0", lane_res(0), 1042440);
    run_job(0, 8, 1'b0, 1'b0);           // R6 zero precision
    run_job(12, 8, 1'b1, 1'b0);          // R6 oversized precision

    // R8: start together with a middle step
    begin_job(4);
    step_once(0, 1'b0);
    step_once(1, 1'b0);
    set_psum(1'b0); step = 1'b1; start = 1'b1; prec = 4'd3;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    for (int l = 0; l < NL; l++) exp_acc[l] = 0;
    chk("R8 mid busy", longint'(busy), 1);
    chk("R8 mid valid", longint'(valid), 0);
    check_all("R8 mid clear");
    for (int k = 0; k < 3; k++) step_once(k, 1'b0);
    chk("R8 restart valid", longint'(valid), 1);
    check_all("R8 restart result");

    // R8: start together with the final step
    begin_job(2);
    step_once(0, 1'b0);
    set_psum(1'b1); step = 1'b1; start = 1'b1; prec = 4'd2;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    for (int l = 0; l < NL; l++) exp_acc[l] = 0;
    chk("R8 last valid", longint'(valid), 0);
    chk("R8 last busy", longint'(busy), 1);
    check_all("R8 last clear");
    step_once(0, 1'b0);
    chk("R8 early", longint'(valid), 0);
    step_once(1, 1'b0);
    chk("R8 final valid", longint'(valid), 1);
    check_all("R8 final result");

    // random jobs
    for (int j = 0; j < 24; j++) begin
      int p;
      p = $urandom_range(1, 8);
      run_job(p, p, 1'b1, 1'b0);
    end
    summary();
  end
endmodule